// File: doc/BRIEF.md
# Fair Daisy-Chain Bus Arbiter

This block decides which of N_DEV bus devices may drive a shared bus. No central selector picks a winner. A single grant token travels along a chain of identical per-device stages, and each link hands it to the next stage. Each device has a request line, a one-cycle release line and a grant output.

While every request line is low, the arbiter sits idle with no token in the chain. The first request starts an arbitration phase, and the token enters stage 0. A stage whose device is not requesting hands the token on after one cycle. A stage whose device is requesting grants the bus and keeps it granted until the device releases it. The token then moves on. When the token leaves the last stage, the phase ends. If any request is pending at that point, a new phase starts at stage 0; otherwise the arbiter goes back to idle.

Because the token passes each stage only once per phase, every requester gets the bus at most once per phase. No requester waits longer than about one full phase.

Top module: `arb_chain`

## Requirements
- R1: A synchronous active-high `rst` drives every `gnt` bit low by the cycle after the reset edge and leaves the chain idle, with no token present.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: While idle with all `req` bits low, `gnt` stays all-zero and the arbiter stays idle.
- R4: From idle, a request sampled at a clock edge puts the token in stage 0 at that edge. If `req[0]` is high, `gnt[0]` rises at the next edge, so the grant appears two edges after the request was first sampled. A grant bit only rises when its `req` bit was high the cycle before.
- R5: A stage holding the token while its `req` is low forwards the token after exactly one cycle and never raises its `gnt`. Each skipped device adds one cycle of latency.
- R6: While `gnt[k]` is high and `done[k]` is low, `gnt[k]` stays high, whatever `req[k]` does.
- R7: `done[k]` high for one cycle while `gnt[k]` is high makes `gnt[k]` fall at the next edge. At that same edge the token enters stage k+1.
- R8: `done[k]` has no effect while `gnt[k]` is low.
- R9: Within a phase, grants are issued in increasing device index, 0 to N_DEV-1.
- R10: A device is granted at most once per phase. A request raised after the token has passed that device waits for the next phase.
- R11: When the token leaves the last stage, stage 0 receives it at the same edge if any `req` bit is high. Otherwise the arbiter becomes idle.
- R12: A requesting device is granted within 2·N_DEV·(H+3)+4 cycles, where H is the longest time any device holds the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_DEV | Per-device bus request |
| done | input | N_DEV | Per-device one-cycle bus release |
| gnt | output | N_DEV | Per-device bus grant, one-hot or zero |

## Verification
Each stage's state can be seen at the ports within one cycle, so a corrupted stage shows up quickly:
- A lost token freezes `gnt` at zero while requests are pending. The fairness bound then trips within one phase.
- A duplicated token raises two grant bits, or grants the same device twice in one phase.
- A stage that skips wrongly or holds wrongly moves the grant by at least one cycle against the cycle-exact reference model, which is compared on every clock.
- A faulty end-of-phase decision either strands requests in idle or starts a phase nobody asked for. Either shows as a `gnt` mismatch one or two cycles after the last stage releases the bus.

// File: rtl/arb_chain_pkg.sv
package arb_chain_pkg;
   typedef enum logic [1:0] {
      STG_EMPTY = 2'd0,
      STG_WAIT  = 2'd1,
      STG_OWN   = 2'd2
   } stage_st_e;
endpackage

// File: rtl/arb_chain_stage.sv
module arb_chain_stage
   import arb_chain_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic tok_in,
   input  logic req,
   input  logic done,
   output logic gnt,
   output logic tok_out
);
   stage_st_e st_q, st_d;

   // Token arrives -> WAIT; WAIT decides own-or-pass in one cycle;
   // OWN leaves only on a release pulse.
   always_comb begin
      st_d    = st_q;
      tok_out = 1'b0;
      case (st_q)
         STG_EMPTY: if (tok_in) st_d = STG_WAIT;
         STG_WAIT: begin
            if (req) begin
               st_d = STG_OWN;
            end else begin
               st_d    = STG_EMPTY;
               tok_out = 1'b1;
            end
         end
         STG_OWN: begin
            if (done) begin
               st_d    = STG_EMPTY;
               tok_out = 1'b1;
            end
         end
         default: st_d = STG_EMPTY;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= STG_EMPTY;
      else     st_q <= st_d;
   end

   assign gnt = (st_q == STG_OWN);
endmodule

// File: rtl/arb_chain_head.sv
module arb_chain_head (
   input  logic clk,
   input  logic rst,
   input  logic req_any,
   input  logic tail_pass,
   output logic inject,
   output logic active
);
   logic active_q;

   // New phase: from idle on any request, or straight after the tail
   // hands the token off while requests are pending.
   assign inject = req_any & (~active_q | tail_pass);

   always_ff @(posedge clk) begin
      if (rst)         active_q <= 1'b0;
      else if (inject) active_q <= 1'b1;
      else if (tail_pass) active_q <= 1'b0;
   end

   assign active = active_q;
endmodule

// File: rtl/arb_chain.sv
module arb_chain #(
   parameter int N_DEV = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_DEV-1:0] req,
   input  logic [N_DEV-1:0] done,
   output logic [N_DEV-1:0] gnt
);
   localparam int LAST = N_DEV - 1;

   if (N_DEV < 2) begin : g_bad_n
      $error("arb_chain: N_DEV must be at least 2");
   end

   logic [N_DEV-1:0] tok_in;
   logic [N_DEV-1:0] tok_pass;
   logic             req_any;
   logic             inject;
   logic             phase_on;

   assign req_any = |req;

   arb_chain_head u_head (
      .clk       (clk),
      .rst       (rst),
      .req_any   (req_any),
      .tail_pass (tok_pass[LAST]),
      .inject    (inject),
      .active    (phase_on)
   );

   for (genvar g = 0; g < N_DEV; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign tok_in[g] = inject;
      end else begin : g_link
         assign tok_in[g] = tok_pass[g-1];
      end

      arb_chain_stage u_stage (
         .clk     (clk),
         .rst     (rst),
         .tok_in  (tok_in[g]),
         .req     (req[g]),
         .done    (done[g]),
         .gnt     (gnt[g]),
         .tok_out (tok_pass[g])
      );
   end
endmodule

// File: rtl/arb_chain_chk.sv
module arb_chain_chk #(
   parameter int N_DEV = 4
) (
   input logic             clk,
   input logic             rst,
   input logic [N_DEV-1:0] req,
   input logic [N_DEV-1:0] done,
   input logic [N_DEV-1:0] gnt,
   input logic             active,
   input logic             tail_pass
);
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (gnt == '0));

   a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (!active && req == '0) |=> (gnt == '0 && !active));

   a_r11_phase_end_idle: assert property (@(posedge clk) disable iff (rst)
      (tail_pass && req == '0) |=> !active);

   for (genvar k = 0; k < N_DEV; k++) begin : g_bit
      a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (rst)
         $rose(gnt[k]) |-> $past(req[k]));

      a_r6_hold: assert property (@(posedge clk) disable iff (rst)
         (gnt[k] && !done[k]) |=> gnt[k]);

      a_r7_release: assert property (@(posedge clk) disable iff (rst)
         (gnt[k] && done[k]) |=> !gnt[k]);
   end
endmodule

bind arb_chain arb_chain_chk #(.N_DEV(N_DEV)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req       (req),
   .done      (done),
   .gnt       (gnt),
   .active    (phase_on),
   .tail_pass (tok_pass[N_DEV-1])
);

// File: tb/test_arb_chain.sv
module test_arb_chain;
   localparam int N        = 4;
   localparam int CLK_P    = 10;
   localparam int HOLD_MAX = 6;
   localparam int WAIT_MAX = 2 * N * (HOLD_MAX + 3) + 4;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] req;
   logic [N-1:0] done;
   logic [N-1:0] gnt;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   arb_chain #(.N_DEV(N)) i_arb_chain (
      .clk(clk), .rst(rst), .req(req), .done(done), .gnt(gnt)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at %0t act=%b exp=%b", tag, $time, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_pos   = -1;   // -1 = idle, else device holding the token
   bit m_own   = 1'b0;
   int m_phase = 0;
   int wait_c [N];

   task model_advance();
      m_own = 1'b0;
      if (m_pos == N-1) begin
         if (|req) begin m_pos = 0; m_phase++; end
         else m_pos = -1;
      end else begin
         m_pos++;
      end
   endtask

   always @(posedge clk) begin
      if (rst) begin
         m_pos = -1; m_own = 1'b0;
         foreach (wait_c[i]) wait_c[i] = 0;
      end else begin
         // R12 fairness: time spent requesting without a grant
         for (int i = 0; i < N; i++) begin
            if (req[i] && !gnt[i]) wait_c[i]++;
            else wait_c[i] = 0;
            if (wait_c[i] > WAIT_MAX) begin
               chk(1'b0, "R12 wait bound", N'(wait_c[i]), N'(WAIT_MAX));
               wait_c[i] = 0;
            end
         end
         if (m_pos < 0) begin
            if (|req) begin m_pos = 0; m_phase++; end
         end else if (!m_own) begin
            if (req[m_pos]) m_own = 1'b1;
            else model_advance();
         end else if (done[m_pos]) begin
            model_advance();
         end
      end
   end

   function automatic logic [N-1:0] model_gnt();
      logic [N-1:0] e = '0;
      if (m_own && m_pos >= 0) e[m_pos] = 1'b1;
      return e;
   endfunction

   // ---------------- per-cycle comparison ----------------
   logic [N-1:0] prev_gnt = '0;
   int last_phase [N];
   initial foreach (last_phase[i]) last_phase[i] = -1;

   always @(negedge clk) begin
      if (!rst && !finished) begin
         chk(gnt == model_gnt(), "R9 cycle compare", gnt, model_gnt());
         for (int i = 0; i < N; i++) begin
            if (gnt[i] && !prev_gnt[i]) begin
               // R10: never twice in the same phase
               chk(last_phase[i] != m_phase, "R10 once per phase",
                   N'(last_phase[i]), N'(m_phase - 1));
               last_phase[i] = m_phase;
            end
         end
         chk($countones(gnt) <= 1, "R2 one-hot", gnt, '0);
      end
      prev_gnt = rst ? '0 : gnt;
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL R12 watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   int hcnt [N];
   int hlen [N];

   initial begin
      rst = 1'b1; req = '0; done = '0;
      repeat (3) @(negedge clk);
      chk(gnt == '0, "R1 reset", gnt, '0);
      rst = 1'b0;

      // R3: idle stays quiet
      repeat (4) tick();
      chk(gnt == '0, "R3 idle", gnt, '0);

      // R4: device 0 alone, two-edge latency
      req = 4'b0001;
      tick(); chk(gnt == '0, "R4 token arrives first", gnt, '0);
      tick(); chk(gnt == 4'b0001, "R4 grant to dev0", gnt, 4'b0001);
      // R6: hold with req dropped
      req = '0;
      repeat (3) tick();
      chk(gnt == 4'b0001, "R6 hold", gnt, 4'b0001);
      // R7: release
      done = 4'b0001;
      tick(); chk(gnt == '0, "R7 release", gnt, '0);
      done = '0;
      repeat (5) tick();
      chk(gnt == '0, "R11 back to idle", gnt, '0);

      // R5/R9: devices 1 and 3
      req = 4'b1010;
      tick(); tick();
      chk(gnt == '0, "R5 skip dev0", gnt, '0);
      tick(); chk(gnt == 4'b0010, "R5 grant dev1", gnt, 4'b0010);
      done = 4'b1000;                       // R8: not granted
      tick(); chk(gnt == 4'b0010, "R8 foreign done ignored", gnt, 4'b0010);
      done = 4'b0010;
      tick(); chk(gnt == '0, "R7 dev1 release", gnt, '0);
      done = '0;                            // dev1 keeps requesting
      tick(); chk(gnt == '0, "R10 dev1 not regranted", gnt, '0);
      tick(); chk(gnt == 4'b1000, "R9 dev3 after dev1", gnt, 4'b1000);
      done = 4'b1000; req = 4'b0010;
      tick(); chk(gnt == '0, "R11 tail release", gnt, '0);
      done = '0;
      tick(); chk(gnt == '0, "R11 new phase skip dev0", gnt, '0);
      tick(); chk(gnt == 4'b0010, "R11 new phase dev1", gnt, 4'b0010);
      req = '0; done = 4'b0010;
      tick(); done = '0;
      repeat (4) tick();
      chk(gnt == '0, "R3 idle again", gnt, '0);

      // R10: late request waits for next phase
      req = 4'b0100;
      repeat (4) tick();
      chk(gnt == 4'b0100, "R5 dev2 after two skips", gnt, 4'b0100);
      req = 4'b0101;
      tick(); chk(gnt == 4'b0100, "R10 late req dev0 waits", gnt, 4'b0100);
      done = 4'b0100; req = 4'b0001;
      tick(); chk(gnt == '0, "R7 dev2 release", gnt, '0);
      done = '0;
      tick(); chk(gnt == '0, "R11 wrap", gnt, '0);
      tick(); chk(gnt == 4'b0001, "R10 dev0 next phase", gnt, 4'b0001);
      done = 4'b0001; req = '0;
      tick(); done = '0;
      repeat (4) tick();

      // random traffic: fairness, once-per-phase, spurious done
      foreach (hcnt[i]) begin hcnt[i] = 0; hlen[i] = 1; end
      for (int cyc = 0; cyc < 4000; cyc++) begin
         logic [N-1:0] nreq = req;
         logic [N-1:0] ndone = '0;
         for (int i = 0; i < N; i++) begin
            if (gnt[i]) begin
               hcnt[i]++;
               if (hcnt[i] >= hlen[i]) begin
                  ndone[i] = 1'b1;
                  nreq[i]  = ($urandom_range(0, 1) == 0);
                  hcnt[i]  = 0;
                  hlen[i]  = $urandom_range(1, HOLD_MAX);
               end
            end else begin
               if (!req[i] && $urandom_range(0, 7) == 0) nreq[i] = 1'b1;
               if ($urandom_range(0, 15) == 0) ndone[i] = 1'b1;   // R8
            end
         end
         req = nreq; done = ndone;
         tick();
      end

      // R1: reset while traffic is live
      req = 4'b1111; done = '0;
      repeat (6) tick();
      rst = 1'b1;
      tick(); chk(gnt == '0, "R1 mid-run reset", gnt, '0);
      req = '0; rst = 1'b0;
      repeat (3) tick();
      chk(gnt == '0, "R1 idle after reset", gnt, '0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule